// File: doc/BRIEF.md
# Time-Sliced Pseudo-Dual-Port RAM Controller

This block puts a single-ported synchronous RAM behind two independent user ports: one that only writes and one that only reads. It does not arbitrate. The memory's time is cut into slots that alternate every clock cycle, a write slot and then a read slot, so each port always owns half of the memory bandwidth whatever the other port is doing. A request that arrives outside its own slot waits for that slot, so requesters must accept a short, bounded latency.

The memory has separate data-in and data-out paths, so only the address is shared, through an internal multiplexer. A four-state machine tracks both the slot and whether the slot owner has work: write slot idle, write slot issuing, read slot idle and read slot issuing. The machine decides in each slot whether the following slot issues, so a request must be present one cycle before its slot to be served there. The whole block runs on one clock and has a synchronous reset.

Both request ports are valid/ready. A transfer happens on a rising edge where valid and ready are both high. Ready rises only in the cycle the access is issued, never depends on valid combinationally, and is the only back-pressure. A requester must hold valid, address and data stable until ready. The read response is a valid pulse with data and has no back-pressure: the receiver must take it in the cycle it appears.

Top module: `tslot_ram_ctrl`

## Requirements
- R1: The slot toggles every cycle. Write handshakes occur only in write-slot cycles and read handshakes only in read-slot cycles, so the cycle distance between any two write handshakes is even and the distance between a write handshake and a read handshake is odd. wr_ready and rd_req_ready are never high together.
- R2: While rst is high at a clock edge, wr_ready, rd_req_ready, rd_rsp_valid and mem_we are low after that edge. The first cycle after reset is an idle write slot, so a write held valid from reset release is acknowledged in the third cycle after release (cycle 2, counting from 0).
- R3: mem_we is high only in a cycle where a write handshake takes place. In such a cycle, mem_addr equals wr_addr and mem_wdata equals wr_data.
- R4: A write request that is valid during a read slot gets wr_ready in the next cycle. A write request first presented during an idle write slot gets wr_ready two cycles later.
- R5: A read request that is valid during a write slot gets rd_req_ready in the next cycle, and mem_addr equals rd_addr in that cycle. A read request first presented during an idle read slot gets rd_req_ready two cycles later.
- R6: rd_rsp_valid is a one-cycle pulse, high exactly two cycles after each read handshake and at no other time. The RAM returns data one cycle after it samples the address, and the block registers that data.
- R7: The data returned for a read is the word most recently written to that address before the read handshake. This holds for every address of the memory.
- R8: With both ports requesting continuously, each port completes one transfer every two cycles, so N transfers on each port finish within 2N+3 cycles.
- R9: With no request valid, wr_ready, rd_req_ready, mem_we and rd_rsp_valid all stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write issued to memory this cycle |
| wr_addr | input | ADDR_W | Write address, held until wr_ready |
| wr_data | input | DATA_W | Write data, held until wr_ready |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read address issued to memory this cycle |
| rd_addr | input | ADDR_W | Read address, held until rd_req_ready |
| rd_rsp_valid | output | 1 | Read data valid pulse |
| rd_rsp_data | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after address |

## Verification
The hardest case to reach from the ports is a read accepted in the slot right after a write to the same address, together with a request that arrives in each of the two slot phases. Single requests are launched with the slot phase known from the first write acknowledge, so both latencies of both ports are measured exactly. Then two back-to-back streams over the same addresses run at once, so reads repeatedly hit words written one cycle earlier. Sequential sweeps over every address of a 16-word memory come first and last, to confirm the contents.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  typedef enum logic [1:0] {
    ST_WR_IDLE = 2'b00,
    ST_WR_GO   = 2'b01,
    ST_RD_IDLE = 2'b10,
    ST_RD_GO   = 2'b11
  } slot_state_t;
endpackage

// File: rtl/tslot_fsm.sv
module tslot_fsm
  import tslot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_pend,
  input  logic        rd_pend,
  output slot_state_t state_o,
  output logic        rd_slot_o,
  output logic        wr_go_o,
  output logic        rd_go_o
);
  slot_state_t state_q, state_d;

  // The decision for the following slot is taken in the current slot.
  always_comb begin
    case (state_q)
      ST_WR_IDLE, ST_WR_GO: state_d = rd_pend ? ST_RD_GO : ST_RD_IDLE;
      default:              state_d = wr_pend ? ST_WR_GO : ST_WR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WR_IDLE;
    else     state_q <= state_d;
  end

  assign state_o   = state_q;
  assign rd_slot_o = (state_q == ST_RD_IDLE) || (state_q == ST_RD_GO);
  assign wr_go_o   = (state_q == ST_WR_GO);
  assign rd_go_o   = (state_q == ST_RD_GO);

  // R1: slots alternate every cycle
  a_r1_rd_then_wr: assert property (@(posedge clk) disable iff (rst)
    rd_slot_o |=> !rd_slot_o);
  a_r1_wr_then_rd: assert property (@(posedge clk) disable iff (rst)
    !rd_slot_o |=> rd_slot_o);
  // R4: write seen in read slot is issued next cycle
  a_r4_write_next: assert property (@(posedge clk) disable iff (rst)
    (rd_slot_o && wr_pend) |=> wr_go_o);
  // R5: read seen in write slot is issued next cycle
  a_r5_read_next: assert property (@(posedge clk) disable iff (rst)
    (!rd_slot_o && rd_pend) |=> rd_go_o);
endmodule

// File: rtl/tslot_addr_mux.sv
module tslot_addr_mux #(
  parameter int ADDR_W = 14
) (
  input  logic              sel_rd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] mem_addr
);
  // Stands in for board-level address buffers: one owner per slot.
  assign mem_addr = sel_rd ? rd_addr : wr_addr;
endmodule

// File: rtl/tslot_rd_capture.sv
module tslot_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic issue_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      issue_q   <= issue;
      rsp_valid <= issue_q;
      if (issue_q) rsp_data <= mem_rdata;
    end
  end

  // R6: reads issue at most every other cycle, so responses are single pulses
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/tslot_ram_ctrl.sv
module tslot_ram_ctrl
  import tslot_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_rsp_valid,
  output logic [DATA_W-1:0] rd_rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  slot_state_t state;
  logic rd_slot, wr_go, rd_go;

  tslot_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_pend(wr_valid), .rd_pend(rd_req_valid),
    .state_o(state), .rd_slot_o(rd_slot), .wr_go_o(wr_go), .rd_go_o(rd_go)
  );

  tslot_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel_rd(rd_slot), .wr_addr(wr_addr), .rd_addr(rd_addr), .mem_addr(mem_addr)
  );

  tslot_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .issue(rd_go), .mem_rdata(mem_rdata),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data)
  );

  assign wr_ready     = wr_go;
  assign rd_req_ready = rd_go;
  assign mem_we       = (state == ST_WR_GO);
  assign mem_wdata    = wr_data;

  // R3: the memory is written only while the read port is not being served
  a_r3_we_not_read: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !rd_req_ready);
  // R6: every response follows a read handshake by two cycles
  a_r6_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid |-> $past(rd_req_valid && rd_req_ready, 2));
  // R1: a write issue is followed by a read slot, never another write
  a_r1_no_double_write: assert property (@(posedge clk) disable iff (rst)
    wr_ready |=> !wr_ready);
endmodule

// File: tb/sim_tslot_ram_ctrl.sv
module sim_tslot_ram_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_req_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_req_ready, rd_rsp_valid, mem_we;
  logic [DW-1:0] rd_rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  tslot_ram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Bench RAM: write on edge, read data one cycle after the address.
  logic [DW-1:0] ram [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int checks = 0, errors = 0, cyc = 0;
  int ref_cyc = 0;
  bit have_ref = 0;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_d [16];
  int exp_c [16];
  int wp = 0, rp = 0, n_rsp = 0, n_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [DW-1:0] wdat(input int a, input int k);
    return DW'((a * 37 + 5 + k * 91) & 255);
  endfunction

  // Port monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) chk(wr_valid && wr_ready, "R3 we without handshake", 1, 0);
      if (wr_valid && wr_ready) begin
        chk(mem_we && mem_addr == wr_addr && mem_wdata == wr_data,
            "R3 write drive", int'(mem_addr), int'(wr_addr));
        chk(!rd_req_ready, "R1 both ready", 1, 0);
        if (have_ref) chk(((cyc - ref_cyc) % 2) == 0, "R1 write parity", cyc - ref_cyc, 0);
        else begin have_ref = 1; ref_cyc = cyc; end
        shadow[wr_addr] = wr_data;
      end
      if (rd_req_valid && rd_req_ready) begin
        chk(mem_addr == rd_addr, "R5 read addr", int'(mem_addr), int'(rd_addr));
        chk(((cyc - ref_cyc) % 2) == 1, "R1 read parity", (cyc - ref_cyc) % 2, 1);
        exp_d[wp] = shadow[rd_addr];
        exp_c[wp] = cyc;
        wp = (wp + 1) % 16;
        n_rd++;
      end
      if (rd_rsp_valid) begin
        if (rp == wp) chk(0, "R6 response without request", 1, 0);
        else begin
          chk(cyc == exp_c[rp] + 2, "R6 response timing", cyc - exp_c[rp], 2);
          chk(rd_rsp_data == exp_d[rp], "R7 read data", int'(rd_rsp_data), int'(exp_d[rp]));
          rp = (rp + 1) % 16;
          n_rsp++;
        end
      end
    end
  end

  task automatic wr_stream(input int n, input int base, input int k);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_addr  = AW'((base + i) % DEPTH);
      wr_data  = wdat((base + i) % DEPTH, k);
      while (!wr_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    wr_valid = 1'b0;
  endtask

  task automatic rd_stream(input int n, input int base);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rd_req_valid = 1'b1;
      rd_addr = AW'((base + i) % DEPTH);
      while (!rd_req_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    rd_req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!wr_ready && !rd_req_ready && !rd_rsp_valid && !mem_we, "R2 reset outputs",
        int'({wr_ready, rd_req_ready, rd_rsp_valid, mem_we}), 0);
    // R2: write held from reset release is acknowledged in cycle 2
    @(posedge clk); #1;
    rst = 1'b0;
    wr_valid = 1'b1; wr_addr = 4'd3; wr_data = 8'h5A;
    @(negedge clk); chk(!wr_ready, "R2 cycle0 ready", int'(wr_ready), 0);
    @(negedge clk); chk(!wr_ready, "R2 cycle1 ready", int'(wr_ready), 0);
    @(negedge clk); chk(wr_ready, "R2 cycle2 ready", int'(wr_ready), 1);
    @(posedge clk); #1; wr_valid = 1'b0;

    // R9: idle ports
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!wr_ready && !rd_req_ready && !mem_we && !rd_rsp_valid, "R9 idle",
          int'({wr_ready, rd_req_ready, mem_we, rd_rsp_valid}), 0);
    end

    // R7: full write sweep then full read sweep
    wr_stream(DEPTH, 0, 0);
    repeat (2) @(posedge clk);
    rd_stream(DEPTH, 0);
    repeat (4) @(posedge clk);
    chk(n_rsp == n_rd, "R6 response count", n_rsp, n_rd);

    // R4, R5: latency from each slot phase
    for (int ph = 0; ph < 2; ph++) begin
      int lat, expl;
      bit wslot;
      repeat (ph + 1) @(negedge clk);
      wslot = ((cyc - ref_cyc) % 2) == 0;
      wr_valid = 1'b1; wr_addr = AW'(ph + 5); wr_data = wdat(ph + 5, 7);
      lat = 0;
      while (!wr_ready) begin @(negedge clk); lat++; end
      expl = wslot ? 2 : 1;
      chk(lat == expl, "R4 write latency", lat, expl);
      @(posedge clk); #1; wr_valid = 1'b0;
      repeat (ph + 1) @(negedge clk);
      wslot = ((cyc - ref_cyc) % 2) == 0;
      rd_req_valid = 1'b1; rd_addr = AW'(ph + 5);
      lat = 0;
      while (!rd_req_ready) begin @(negedge clk); lat++; end
      expl = wslot ? 1 : 2;
      chk(lat == expl, "R5 read latency", lat, expl);
      @(posedge clk); #1; rd_req_valid = 1'b0;
      repeat (3) @(posedge clk);
    end

    // R8: both ports streaming over the same addresses
    begin
      int t0;
      @(posedge clk); #1;
      t0 = cyc;
      fork
        wr_stream(DEPTH, 0, 1);
        rd_stream(DEPTH, 0);
      join
      chk(cyc - t0 <= 2 * DEPTH + 3, "R8 throughput", cyc - t0, 2 * DEPTH + 3);
    end
    repeat (4) @(posedge clk);
    rd_stream(DEPTH, 0);
    repeat (4) @(posedge clk);
    chk(n_rsp == n_rd, "R6 final response count", n_rsp, n_rd);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule